// File: doc/BRIEF.md
# Rectangle Copy and Fill Engine

This is a small 2D engine that works on a frame store of one byte per pixel. The frame store is a synthesizable memory inside the block. The host programs it over a 32-bit register bus. It writes a line-pitch word, a source address, a destination address, a control word, a foreground colour and a size word. Writing the size word launches the job. The engine then moves one byte per clock until the rectangle is done, and shows a busy flag the whole time.

Three raster operations are supported:
- **Copy:** each destination byte takes the source byte.
- **Invert destination:** each destination byte is complemented, which is how a text cursor is drawn.
- **Pattern fill:** each destination byte takes the foreground colour.

Two direction flags choose the walk order, so copies between overlapping rectangles stay correct:
- One flag walks each row from high to low addresses.
- The other walks the rows from last to first.

When a flag is set, the host gives the start addresses at that far corner of the rectangle. The host can also read and write single frame-store bytes through an address window while the engine is idle.

Top module: `rect_blit`

## Requirements
- R1: After reset, `busy` is 0 and the control, size and pitch registers read as 0.
- R2: The bus address has its top bit clear for registers. Register index 0 is the pitch word: bits 31:16 are the source pitch and bits 15:0 the destination pitch. Index 1 is the source address, 2 the destination address, 3 the control word, 4 the foreground colour and 5 the size word (bits 31:16 height, bits 15:0 width in bytes). A read of any of them returns the value written one cycle after `bus_rd`, and control bit 31 reads the live busy state.
- R3: A write to the size register while idle, with non-zero height and width, raises `busy` on the next clock. `busy` then stays high for exactly width × height cycles, one byte per cycle.
- R4: With both direction flags clear, row r, column c reads source address src + r·src_pitch + c and writes destination address dst + r·dst_pitch + c, in row-major ascending order.
- R5: Control bit 8 (right-to-left) makes the column term −c instead of +c.
- R6: Control bit 9 (bottom-to-top) makes the row terms −r·pitch instead of +r·pitch.
- R7: For a copy between overlapping rectangles, in every one of the four flag combinations, the frame store ends equal to a byte-by-byte sequential copy in the stated order.
- R8: Control byte 0x55 replaces each destination byte by its bitwise complement.
- R9: Control byte 0xF0 (pattern), used with the solid flag (bit 10) and the mono flag (bit 11), writes the low byte of the foreground register to every destination byte. Any other control byte, including 0xCC, copies.
- R10: While `busy` is high, all bus writes are ignored, to registers and to the frame store alike, and that includes a second size write.
- R11: A size write with width 0 or height 0 leaves `busy` low and changes no frame-store byte.
- R12: When the bus address has its top bit set, the low bits address a frame-store byte. Writes store bit 7:0 while idle, and reads return the byte zero-extended with `bus_rvalid` one cycle after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | $clog2(MEM_DEPTH)+1 | Top bit selects the frame store; otherwise bits 2:0 select a register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| busy | output | 1 | Engine running |

## Verification
The engine's own write port and the host's frame-store write port can both fall in the same clock. The bench provokes this by issuing host byte writes, register writes and a second size write while a long copy is running. It judges the result by reading every byte and register afterwards: the host writes must have been dropped, and the busy time must still equal width × height. Overlapping copies in all four direction combinations are compared byte for byte against a sequential model in the bench.

// File: rtl/rect_blit.sv
module rect_blit #(
  parameter int MEM_DEPTH = 4096
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  input  logic [$clog2(MEM_DEPTH):0]    bus_addr,
  input  logic [31:0]                   bus_wdata,
  output logic [31:0]                   bus_rdata,
  output logic                          bus_rvalid,
  output logic                          busy
);
  localparam int MA = $clog2(MEM_DEPTH);
  localparam int AW = MA + 1;
  localparam logic [7:0] OP_INV = 8'h55;
  localparam logic [7:0] OP_PAT = 8'hF0;
  localparam logic [2:0] IX_PITCH = 3'd0, IX_SRC = 3'd1, IX_DST = 3'd2,
                         IX_CTRL = 3'd3, IX_FG = 3'd4, IX_SIZE = 3'd5;

  logic [31:0] r_pitch, r_src, r_dst, r_ctrl, r_fg, r_size;
  logic [7:0]  fb [MEM_DEPTH];
  logic [MA-1:0] row_src, row_dst, cur_src, cur_dst;
  logic [15:0] col, row;

  wire          is_mem  = bus_addr[AW-1];
  wire [2:0]    ridx    = bus_addr[2:0];
  wire [MA-1:0] maddr   = bus_addr[MA-1:0];
  wire          host_wr = bus_wr & ~busy;
  wire          size_wr = host_wr & ~is_mem & (ridx == IX_SIZE);
  wire          launch  = size_wr & (|bus_wdata[15:0]) & (|bus_wdata[31:16]);

  wire [15:0]   width   = r_size[15:0];
  wire [15:0]   height  = r_size[31:16];
  wire [MA-1:0] s_pitch = r_pitch[16 +: MA];
  wire [MA-1:0] d_pitch = r_pitch[0 +: MA];
  wire          go_left = r_ctrl[8];
  wire          go_up   = r_ctrl[9];
  wire          end_col = (col == width - 16'd1);
  wire          end_row = (row == height - 16'd1);

  wire [MA-1:0] nxt_row_src = go_up ? row_src - s_pitch : row_src + s_pitch;
  wire [MA-1:0] nxt_row_dst = go_up ? row_dst - d_pitch : row_dst + d_pitch;

  logic [7:0] pix;
  always_comb begin
    case (r_ctrl[7:0])
      OP_INV:  pix = ~fb[cur_dst];
      OP_PAT:  pix = r_fg[7:0];
      default: pix = fb[cur_src];
    endcase
  end

  always_ff @(posedge clk) begin
    if (busy) fb[cur_dst] <= pix;
    else if (host_wr && is_mem) fb[maddr] <= bus_wdata[7:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_pitch <= '0; r_src <= '0; r_dst <= '0;
      r_ctrl  <= '0; r_fg  <= '0; r_size <= '0;
    end else if (host_wr && !is_mem) begin
      case (ridx)
        IX_PITCH: r_pitch <= bus_wdata;
        IX_SRC:   r_src   <= bus_wdata;
        IX_DST:   r_dst   <= bus_wdata;
        IX_CTRL:  r_ctrl  <= {1'b0, bus_wdata[30:0]};
        IX_FG:    r_fg    <= bus_wdata;
        IX_SIZE:  r_size  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      col <= '0; row <= '0;
      row_src <= '0; row_dst <= '0; cur_src <= '0; cur_dst <= '0;
    end else if (launch) begin
      busy <= 1'b1;
      col <= '0; row <= '0;
      row_src <= r_src[MA-1:0]; cur_src <= r_src[MA-1:0];
      row_dst <= r_dst[MA-1:0]; cur_dst <= r_dst[MA-1:0];
    end else if (busy) begin
      if (end_col) begin
        col <= '0;
        if (end_row) busy <= 1'b0;
        row <= row + 16'd1;
        row_src <= nxt_row_src; cur_src <= nxt_row_src;
        row_dst <= nxt_row_dst; cur_dst <= nxt_row_dst;
      end else begin
        col <= col + 16'd1;
        cur_src <= go_left ? cur_src - 1'b1 : cur_src + 1'b1;
        cur_dst <= go_left ? cur_dst - 1'b1 : cur_dst + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) begin
        if (is_mem) bus_rdata <= {24'd0, fb[maddr]};
        else begin
          case (ridx)
            IX_PITCH: bus_rdata <= r_pitch;
            IX_SRC:   bus_rdata <= r_src;
            IX_DST:   bus_rdata <= r_dst;
            IX_CTRL:  bus_rdata <= {busy, r_ctrl[30:0]};
            IX_FG:    bus_rdata <= r_fg;
            IX_SIZE:  bus_rdata <= r_size;
            default:  bus_rdata <= '0;
          endcase
        end
      end
    end
  end

  logic [31:0] run_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n || launch) run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + 32'd1;
  end

  assert_busy_from_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(launch));
  assert_run_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_cnt == {16'd0, width} * {16'd0, height});
  assert_zero_size_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (size_wr && !launch) |=> !busy);
  assert_regs_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$rose(busy)) |-> ($stable(r_src) && $stable(r_dst) && $stable(r_size)
                                && $stable(r_ctrl) && $stable(r_pitch) && $stable(r_fg)));
  assert_walk_inside_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (col < width && row < height));
  assert_read_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_rd));
endmodule

// File: tb/tb_rect_blit.sv
module tb_rect_blit;
  localparam int MEM_DEPTH = 4096;
  localparam int MA = $clog2(MEM_DEPTH);
  localparam int REGION = 1024;

  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0;
  logic [MA:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid, busy;

  rect_blit #(.MEM_DEPTH(MEM_DEPTH)) dut (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0, busy_cycles = 0;
  logic [7:0] model [REGION];
  logic [31:0] exp_q [$];
  string tag_q [$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (busy) busy_cycles++;
    if (bus_rvalid) begin
      if (exp_q.size() == 0) check(0, "R12 unexpected rvalid", bus_rdata, 0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(bus_rdata == e, t, bus_rdata, e);
      end
    end
  end

  function automatic logic [MA:0] reg_a(input int k);
    return {1'b0, MA'(k)};
  endfunction
  function automatic logic [MA:0] mem_a(input int a);
    return {1'b1, MA'(a)};
  endfunction

  task automatic wr(input logic [MA:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [MA:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic verify_mem(input string tag);
    for (int a = 0; a < REGION; a++) begin
      @(negedge clk);
      bus_rd = 1; bus_addr = mem_a(a);
      exp_q.push_back({24'd0, model[a]}); tag_q.push_back(tag);
    end
    @(negedge clk);
    bus_rd = 0;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic model_op(input logic [31:0] ctrl, input int src, input int dst,
                          input int sp, input int dp, input logic [7:0] fg, input int w, input int h);
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++) begin
        int s, d;
        s = src + (ctrl[9] ? -r : r) * sp + (ctrl[8] ? -c : c);
        d = dst + (ctrl[9] ? -r : r) * dp + (ctrl[8] ? -c : c);
        case (ctrl[7:0])
          8'h55:   model[d] = ~model[d];
          8'hF0:   model[d] = fg;
          default: model[d] = model[s];
        endcase
      end
  endtask

  task automatic run_op(input string tag, input logic [31:0] ctrl, input int src, input int dst,
                        input int sp, input int dp, input logic [7:0] fg, input int w, input int h);
    wr(reg_a(0), {sp[15:0], dp[15:0]});
    wr(reg_a(1), src);
    wr(reg_a(2), dst);
    wr(reg_a(3), ctrl);
    wr(reg_a(4), {24'd0, fg});
    busy_cycles = 0;
    wr(reg_a(5), {h[15:0], w[15:0]});
    while (busy) @(negedge clk);
    check(busy_cycles == w * h, {tag, " R3 busy length"}, busy_cycles, w * h);
    model_op(ctrl, src, dst, sp, dp, fg, w, h);
    verify_mem(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    check(busy == 0, "R1 busy after reset", busy, 0);
    rd(reg_a(3), 0, "R1 control after reset");
    rd(reg_a(5), 0, "R1 size after reset");
    rd(reg_a(0), 0, "R1 pitch after reset");

    wr(reg_a(0), 32'h0010_0020);
    rd(reg_a(0), 32'h0010_0020, "R2 pitch readback");
    wr(reg_a(4), 32'h0000_00C3);
    rd(reg_a(4), 32'h0000_00C3, "R2 colour readback");

    for (int a = 0; a < REGION; a++) begin
      model[a] = 8'((a * 7 + 3) ^ (a >> 5));
      wr(mem_a(a), {24'd0, model[a]});
    end
    verify_mem("R12 frame store load");

    run_op("R4 plain copy", 32'hCC, 0, 600, 32, 32, 0, 10, 4);
    run_op("R4 distinct pitches", 32'hCC, 64, 700, 16, 32, 0, 8, 5);
    run_op("R7 overlap ascending", 32'hCC, 200, 167, 32, 32, 0, 12, 6);
    run_op("R5 R7 overlap right-to-left", 32'h1CC, 411, 416, 32, 32, 0, 12, 6);
    run_op("R6 R7 overlap bottom-to-top", 32'h2CC, 260, 324, 32, 32, 0, 12, 6);
    run_op("R5 R6 R7 overlap both", 32'h3CC, 621, 656, 32, 32, 0, 12, 6);
    run_op("R8 invert", 32'h55, 0, 800, 32, 32, 0, 6, 3);
    run_op("R9 pattern fill", 32'hCF0, 0, 900, 32, 32, 8'hA5, 7, 2);
    run_op("R9 unknown op copies", 32'h12, 5, 950, 32, 32, 0, 4, 2);

    wr(reg_a(3), 32'hCC);
    wr(reg_a(2), 850);
    busy_cycles = 0;
    wr(reg_a(5), 32'h0003_0000);
    repeat (4) @(negedge clk);
    check(busy_cycles == 0, "R11 zero width stays idle", busy_cycles, 0);
    wr(reg_a(5), 32'h0000_0005);
    repeat (4) @(negedge clk);
    check(busy_cycles == 0, "R11 zero height stays idle", busy_cycles, 0);
    verify_mem("R11 memory untouched");

    wr(reg_a(0), 32'h0020_0020);
    wr(reg_a(1), 0);
    wr(reg_a(2), 300);
    wr(reg_a(3), 32'hCC);
    busy_cycles = 0;
    wr(reg_a(5), 32'h0008_0020);
    check(busy == 1, "R3 busy after launch", busy, 1);
    rd(reg_a(3), 32'h8000_00CC, "R2 control busy bit");
    wr(reg_a(2), 999);
    wr(mem_a(1000), 32'h77);
    wr(reg_a(5), 32'h0001_0001);
    while (busy) @(negedge clk);
    check(busy_cycles == 256, "R10 busy length with writes", busy_cycles, 256);
    rd(reg_a(2), 300, "R10 destination register kept");
    rd(reg_a(5), 32'h0008_0020, "R10 size register kept");
    model_op(32'hCC, 0, 300, 32, 32, 0, 32, 8);
    verify_mem("R10 R7 memory after busy writes");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule